// File: doc/BRIEF.md
# Bus-Mastering Byte Copy Engine

This block moves a block of bytes from one memory region to another on behalf of the processor, without the processor touching the data. Software loads a source address, a destination address, a byte count and a mode bit and pulses a start strobe. From then on the engine borrows the shared memory bus whenever it needs it. It uses a four-phase ownership exchange: it requests the bus, the processor grants it, the engine acknowledges the grant, and when it is done it signals release and waits for the processor to confirm.

Each byte is a read from the current source address into a holding register, followed by a write of that register to the current destination address. Both pointers then advance by one. In byte-stealing mode the bus is handed back after every byte and a fresh request waits for the peripheral's data-ready input, so the processor runs between bytes. In whole-block mode the bus is kept from the first byte to the last. When the count is exhausted the engine raises an interrupt that stays up until software clears it.

Top module: `dma_engine`

## Requirements
- R1: The engine never asserts `grant_ack`, `mem_rd` or `mem_wr` unless `bus_grant` is high, and while `bus_grant` is withheld it keeps `bus_req` high with no memory strobe.
- R2: `grant_ack` is high in the cycle before every read or write strobe, so the acknowledge always precedes the first transfer cycle of an ownership period.
- R3: Byte i of a transfer is read at address src+i and written at address dst+i (8-bit wrap) with the value returned by memory. Read data is taken the cycle after `mem_rd`, and `mem_rd` and `mem_wr` are never high together.
- R4: To give the bus back the engine holds `bus_rel` high with `bus_req`, `grant_ack` and both strobes low, and keeps it high until `rel_ack` is seen.
- R5: With mode bit 0 (byte-stealing) the bus is requested once per byte and released after each byte. No request is made while `dev_ready` is low.
- R6: With mode bit 1 (whole-block) a single request covers the entire count.
- R7: `irq` rises in the cycle in which the last release is acknowledged and stays high until `irq_clr` is pulsed. It is low the cycle after the clear.
- R8: A start strobe while `busy` is high is ignored: the running copy keeps its addresses and count, and the new destination is left untouched.
- R9: A start with a count of zero sets `irq` on the next cycle, never asserts `bus_req` and leaves `busy` low.
- R10: After reset `bus_req`, `grant_ack`, `bus_rel`, `mem_rd`, `mem_wr`, `busy` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Start strobe, one cycle |
| cmd_mode | input | 1 | 0 byte-stealing, 1 whole-block |
| cmd_src | input | AW | First source address |
| cmd_dst | input | AW | First destination address |
| cmd_len | input | CW | Number of bytes to copy |
| irq_clr | input | 1 | Clears the completion interrupt |
| dev_ready | input | 1 | Peripheral has the next byte available |
| bus_grant | input | 1 | Processor grants the bus |
| rel_ack | input | 1 | Processor confirms the bus was returned |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| bus_req | output | 1 | Bus request |
| grant_ack | output | 1 | Acknowledge of the grant, high while master |
| bus_rel | output | 1 | Bus release |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| busy | output | 1 | A copy is in progress |
| irq | output | 1 | Completion interrupt |

## Verification
With a processor model that grants one cycle after a request, a byte-stealing byte takes about ten cycles from request to release acknowledge, and a whole-block byte adds three cycles (read, capture, write). The bench drives inputs and samples every output on the falling edge. It checks each strobe's address and data in the same half-cycle the strobe is visible, so the check does not depend on the total latency. The interrupt and the zero-count response are checked on the first falling edge after the edge that must produce them. Transfer completion is awaited by polling `busy` rather than by counting a fixed number of cycles.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_REQ, ST_ACK, ST_RD, ST_CAP, ST_WR, ST_REL
  } dma_st_t;
  localparam logic MODE_STEAL = 1'b0;
  localparam logic MODE_BLOCK = 1'b1;
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] len_in,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          last,
  output logic          rem_zero
);
  logic [CW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= '0;
      dst <= '0;
      rem <= '0;
    end else if (load) begin
      src <= src_in;
      dst <= dst_in;
      rem <= len_in;
    end else if (step) begin
      src <= src + 1'b1;
      dst <= dst + 1'b1;
      rem <= rem - 1'b1;
    end
  end

  assign last     = (rem == CW'(1));
  assign rem_zero = (rem == '0);
endmodule

// File: rtl/dma_hold.sv
module dma_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (cap) dout <= din;
  end
endmodule

// File: rtl/dma_irq.sv
module dma_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
  import dma_eng_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    go,
  input  logic    go_mode,
  input  logic    len_zero,
  input  logic    dev_ready,
  input  logic    bus_grant,
  input  logic    rel_ack,
  input  logic    last,
  input  logic    rem_zero,
  output dma_st_t state,
  output logic    load,
  output logic    step,
  output logic    done
);
  dma_st_t nxt;
  logic    mode_q;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    step = 1'b0;
    done = 1'b0;
    unique case (state)
      ST_IDLE: if (go) begin
        if (len_zero) done = 1'b1;
        else begin
          load = 1'b1;
          nxt  = ST_WAIT;
        end
      end
      ST_WAIT: if (dev_ready) nxt = ST_REQ;
      ST_REQ:  if (bus_grant) nxt = ST_ACK;
      ST_ACK:  nxt = ST_RD;
      ST_RD:   nxt = ST_CAP;
      ST_CAP:  nxt = ST_WR;
      ST_WR: begin
        step = 1'b1;
        nxt  = (last || mode_q == MODE_STEAL) ? ST_REL : ST_RD;
      end
      ST_REL: if (rel_ack) begin
        if (rem_zero) begin
          done = 1'b1;
          nxt  = ST_IDLE;
        end else begin
          nxt = ST_WAIT;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_q <= MODE_STEAL;
    end else begin
      state <= nxt;
      if (load) mode_q <= go_mode;
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_eng_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_go,
  input  logic          cmd_mode,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [CW-1:0] cmd_len,
  input  logic          irq_clr,
  input  logic          dev_ready,
  input  logic          bus_grant,
  input  logic          rel_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic          grant_ack,
  output logic          bus_rel,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          irq
);
  dma_st_t       state;
  logic          load, step, done, last, rem_zero;
  logic [AW-1:0] src, dst;

  dma_ctl u_ctl (
    .clk(clk), .rst(rst), .go(cmd_go), .go_mode(cmd_mode),
    .len_zero(cmd_len == '0), .dev_ready(dev_ready), .bus_grant(bus_grant),
    .rel_ack(rel_ack), .last(last), .rem_zero(rem_zero),
    .state(state), .load(load), .step(step), .done(done)
  );

  dma_ptr #(.AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .src_in(cmd_src), .dst_in(cmd_dst), .len_in(cmd_len),
    .src(src), .dst(dst), .last(last), .rem_zero(rem_zero)
  );

  dma_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .cap(state == ST_CAP), .din(mem_rdata), .dout(mem_wdata)
  );

  dma_irq u_irq (
    .clk(clk), .rst(rst), .set(done), .clr(irq_clr), .irq(irq)
  );

  // Outputs decode the registered state only.
  assign grant_ack = (state == ST_ACK) || (state == ST_RD) ||
                     (state == ST_CAP) || (state == ST_WR);
  assign bus_req   = (state == ST_REQ) || grant_ack;
  assign bus_rel   = (state == ST_REL);
  assign mem_rd    = (state == ST_RD);
  assign mem_wr    = (state == ST_WR);
  assign mem_addr  = mem_wr ? dst : src;
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_go,
  input logic [CW-1:0] cmd_len,
  input logic          busy,
  input logic          irq,
  input logic          irq_clr,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          grant_ack,
  input logic          bus_rel,
  input logic          rel_ack,
  input logic          mem_rd,
  input logic          mem_wr
);
  // R1
  owner_only_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr || grant_ack) |-> bus_grant);

  // R2
  ack_before_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> $past(grant_ack));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));

  // R4
  release_clean_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rel |-> (!bus_req && !grant_ack && !mem_rd && !mem_wr));

  // R4
  release_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rel && !rel_ack) |=> bus_rel);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && !busy && cmd_len == '0) |=> (irq && !bus_req && !busy));
endmodule

bind dma_engine dma_engine_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_len(cmd_len), .busy(busy),
  .irq(irq), .irq_clr(irq_clr), .bus_req(bus_req), .bus_grant(bus_grant),
  .grant_ack(grant_ack), .bus_rel(bus_rel), .rel_ack(rel_ack),
  .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cmd_go, cmd_mode, irq_clr, dev_ready, bus_grant, rel_ack;
  logic [AW-1:0] cmd_src, cmd_dst, mem_addr;
  logic [CW-1:0] cmd_len;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic bus_req, grant_ack, bus_rel, mem_rd, mem_wr, busy, irq;

  dma_engine #(.AW(AW), .CW(CW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_mode(cmd_mode),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .irq_clr(irq_clr), .dev_ready(dev_ready), .bus_grant(bus_grant),
    .rel_ack(rel_ack), .mem_rdata(mem_rdata), .bus_req(bus_req),
    .grant_ack(grant_ack), .bus_rel(bus_rel), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .busy(busy), .irq(irq)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] a);
    return 8'(a * 8'd37 + 8'd11);
  endfunction

  // Memory and processor models
  logic [7:0] mem [256];
  logic withhold = 1'b0;

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (rst) begin
      bus_grant <= 1'b0;
      rel_ack   <= 1'b0;
    end else begin
      bus_grant <= bus_req && !withhold;
      rel_ack   <= bus_rel;
    end
  end

  // Strobe monitor
  logic [7:0] exp_src = '0, exp_dst = '0;
  int rd_n = 0, wr_n = 0, req_n = 0;
  bit prev_req = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && !prev_req) req_n++;
      prev_req = bus_req;
      if (mem_rd) begin
        chk(mem_addr == 8'(exp_src + rd_n), "R3 read address", mem_addr, 8'(exp_src + rd_n));
        rd_n++;
      end
      if (mem_wr) begin
        chk(mem_addr == 8'(exp_dst + wr_n), "R3 write address", mem_addr, 8'(exp_dst + wr_n));
        chk(mem_wdata == pat(8'(exp_src + wr_n)), "R3 write data", mem_wdata, pat(8'(exp_src + wr_n)));
        wr_n++;
      end
    end
  end

  task automatic fill;
    for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
  endtask

  task automatic start_xfer(input logic m, input logic [7:0] s, input logic [7:0] d, input logic [7:0] n);
    exp_src = s; exp_dst = d; rd_n = 0; wr_n = 0; req_n = 0;
    cmd_mode = m; cmd_src = s; cmd_dst = d; cmd_len = n; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_done;
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, "transfer finished in time", busy, 0);
  endtask

  task automatic clear_irq;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  // {mode, src, dst, len}
  localparam logic [24:0] VEC [4] = '{
    {1'b0, 8'h10, 8'h80, 8'd3},
    {1'b1, 8'h20, 8'h90, 8'd5},
    {1'b1, 8'h40, 8'hA0, 8'd1},
    {1'b0, 8'hFE, 8'hC0, 8'd4}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_go = 1'b0; cmd_mode = 1'b0; cmd_src = '0; cmd_dst = '0;
    cmd_len = '0; irq_clr = 1'b0; dev_ready = 1'b1;
    fill();
    repeat (4) @(negedge clk);
    // R10 reset state
    chk({bus_req, grant_ack, bus_rel, mem_rd, mem_wr, busy, irq} == '0,
        "R10 outputs low in reset", {bus_req, grant_ack, bus_rel, mem_rd, mem_wr, busy, irq}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({bus_req, busy, irq} == '0, "R10 idle after reset", {bus_req, busy, irq}, 0);

    // Vector table: R3, R5, R6, R7
    for (int v = 0; v < 4; v++) begin
      logic m;
      logic [7:0] s, d, n;
      {m, s, d, n} = VEC[v];
      fill();
      start_xfer(m, s, d, n);
      chk(busy, "R8 busy after start", busy, 1);
      wait_done();
      chk(irq, "R7 irq at completion", irq, 1);
      if (m) chk(req_n == 1, "R6 one request for whole block", req_n, 1);
      else   chk(req_n == int'(n), "R5 one request per byte", req_n, int'(n));
      for (int i = 0; i < int'(n); i++)
        chk(mem[8'(d + i)] == pat(8'(s + i)), "R3 destination byte", mem[8'(d + i)], pat(8'(s + i)));
      chk(mem[8'(d + n)] == pat(8'(d + n)), "R3 byte past end untouched", mem[8'(d + n)], pat(8'(d + n)));
      repeat (5) @(negedge clk);
      chk(irq, "R7 irq held until cleared", irq, 1);
      clear_irq();
      chk(!irq, "R7 irq low after clear", irq, 0);
    end

    // R9 zero count
    start_xfer(1'b0, 8'h00, 8'h00, 8'd0);
    chk(irq && !busy && !bus_req, "R9 zero count finishes at once", {irq, busy, bus_req}, 3'b100);
    repeat (4) @(negedge clk);
    chk(req_n == 0, "R9 no bus request for zero count", req_n, 0);
    clear_irq();

    // R8 start while busy is ignored
    fill();
    start_xfer(1'b1, 8'h30, 8'h60, 8'd4);
    repeat (3) @(negedge clk);
    cmd_src = 8'h00; cmd_dst = 8'hE0; cmd_len = 8'd2; cmd_mode = 1'b0; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
    wait_done();
    chk(wr_n == 4, "R8 original count kept", wr_n, 4);
    chk(mem[8'hE0] == pat(8'hE0), "R8 new destination untouched", mem[8'hE0], pat(8'hE0));
    chk(mem[8'h63] == pat(8'h33), "R8 original copy complete", mem[8'h63], pat(8'h33));
    clear_irq();

    // R1 grant withheld
    withhold = 1'b1;
    start_xfer(1'b0, 8'h50, 8'h70, 8'd1);
    repeat (8) @(negedge clk);
    chk(bus_req && !grant_ack && rd_n == 0, "R1 waits for grant", {bus_req, grant_ack}, 2'b10);
    withhold = 1'b0;
    wait_done();
    chk(wr_n == 1, "R1 byte moved after grant", wr_n, 1);
    clear_irq();

    // R5 data-ready gating in byte-stealing mode
    dev_ready = 1'b0;
    start_xfer(1'b0, 8'h08, 8'hB0, 8'd2);
    repeat (8) @(negedge clk);
    chk(!bus_req && busy, "R5 no request while not ready", bus_req, 0);
    dev_ready = 1'b1;
    begin
      int n = 0;
      while (!bus_rel && n < 100) begin @(negedge clk); n++; end
    end
    dev_ready = 1'b0;
    repeat (10) @(negedge clk);
    chk(!bus_req && wr_n == 1, "R5 second request held off", wr_n, 1);
    chk(req_n == 1, "R5 single request so far", req_n, 1);
    dev_ready = 1'b1;
    wait_done();
    chk(req_n == 2 && wr_n == 2, "R5 second byte after ready", req_n, 2);
    chk(irq, "R7 irq after gated transfer", irq, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule